// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-facing register front end of a multi-channel interval timer. It sits on an 8-bit parallel bus with an active-low chip select, active-low read and write strobes and a 2-bit address. Addresses 0 to 2 reach the three channels and address 3 reaches the command register. Through this bus software programs each channel's format and mode, loads initial counts byte by byte, and reads the running counts back in the programmed byte order.

A command written at address 3 does one of three things. It can reprogram one channel. It can freeze one channel's count for a later read. It can freeze the count, the status, or both on any subset of channels at once. A frozen value is held until software has read it completely, and further freeze requests in the meantime are ignored. When a channel holds both a frozen status and a frozen count, the status byte is returned first.

The counting engine is a separate block. It supplies each channel's live count, output level and null-count flag. In return it gets the assembled 16-bit count register, a one-cycle pulse when that register is complete, a pulse on reprogramming, and the six format/mode bits. The whole interface runs on one system clock, and the bus strobes are edge-detected against their registered values.

Top module: `tmr_host_if`

## Requirements
- R1: After the synchronous active-low reset, every channel's control bits read 6'b010000 (low byte only, mode 0, binary), every count register is zero, no strobe is high and `rdata_oe` is low.
- R2: A bus access counts only on the falling edge of its strobe while `cs_n` is low and the other strobe is high. A write with `cs_n` high has no effect, and neither has a cycle with both strobes low. `rdata_oe` is high only for a read at address 0 to 2; a read at address 3 leaves it low.
- R3: A write at address 3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are not 00 is a control word. Bits 5:4 select the access format (01 low byte, 10 high byte, 11 low then high), bits 3:1 the mode and bit 0 BCD. That channel's `ctrl_word` takes bits 5:0, `cw_stb` pulses for one cycle, its count register is cleared and its read and write byte pointers return to the first byte.
- R4: A count write in a one-byte format replaces that byte, keeps the other byte and pulses `cr_stb`. In the low-then-high format the first write fills the low byte without a pulse, and the second fills the high byte and pulses `cr_stb`.
- R5: Bits 5:4 = 00 on a control write (bits 7:6 naming a channel) freeze that channel's live count and leave its `ctrl_word` unchanged. A further freeze request before the frozen value is fully read is ignored.
- R6: Reads return the low byte, the high byte, or low then high according to the format. A frozen count is released after its last byte is read, and later reads return the live count. Read data appears on `rdata` in the cycle after the strobe edge.
- R7: A control write with bits 7:6 = 11 is a multi-channel command. Bit 5 low freezes the count and bit 4 low freezes the status of every channel whose select bit is set (bit 1 channel 0, bit 2 channel 1, bit 3 channel 2).
- R8: A frozen status byte carries the output level in bit 7, the null-count flag in bit 6 and the channel's `ctrl_word` in bits 5:0. A further status freeze before it is read is ignored.
- R9: With both status and count frozen, the first read returns the status and the following one or two reads return the frozen count.
- R10: In the low-then-high format, reads and writes of one channel keep separate byte pointers that may interleave. Accesses to other channels do not move them.
- R11: Reprogramming a channel discards any frozen count or status, so the next read returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel 0-2 or command register 3 |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, registered |
| rdata_oe | output | 1 | High while the bus should be driven |
| live_cnt | input | NCH*16 | Live count per channel from the engine |
| out_lvl | input | NCH | Output level per channel |
| null_flag | input | NCH | Null-count flag per channel |
| cr_val | output | NCH*16 | Assembled count register per channel |
| cr_stb | output | NCH | One-cycle pulse: count register complete |
| cw_stb | output | NCH | One-cycle pulse: channel reprogrammed |
| ctrl_word | output | NCH*6 | Format, mode and BCD bits per channel |

## Verification
Two functions can meet in one cycle. A snapshot taken by a freeze command competes with the live count moving right after it. A multi-channel command can freeze count and status together, which then competes with the read-order rule. The bench freezes count and status with one command while setting different output levels, null flags and counts, then changes every engine input before reading. It judges each returned byte against the values present at the command, status first. Interleaved reads and writes of one channel, with foreign-channel traffic between them, check that the two byte pointers do not disturb each other.

// File: rtl/tmr_pkg.sv
// Shared encodings of the timer host interface.
// Assumes: control word fields as described in the brief.
package tmr_pkg;

    typedef enum logic [1:0] {
        ACC_FREEZE = 2'b00,
        ACC_LO     = 2'b01,
        ACC_HI     = 2'b10,
        ACC_BOTH   = 2'b11
    } acc_e;

    localparam logic [1:0] SEL_MULTI  = 2'b11;
    localparam logic [5:0] CTRL_RESET = 6'b010000;

endpackage

// File: rtl/tmr_bus_decode.sv
// Bus front end: detects strobe edges against registered copies and turns
// each qualified access into per-channel request pulses.
// Assumes: at most one access per strobe, NCH <= 3, address 3 = command.
module tmr_bus_decode #(
    parameter int NCH    = 3,
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [NCH-1:0]    ch_we,
    output logic [NCH-1:0]    ch_re,
    output logic [NCH-1:0]    prog,
    output logic [NCH-1:0]    frz_cnt,
    output logic [NCH-1:0]    frz_stat
);
    import tmr_pkg::*;

    localparam logic [ADDR_W-1:0] CMD_ADDR = '1;

    logic rd_n_q, wr_n_q;
    logic wr_edge, rd_edge, cmd_wr, is_multi;
    logic [1:0] sel;
    acc_e acc;

    // Purpose: keep last-cycle strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
        end else begin
            rd_n_q <= rd_n;
            wr_n_q <= wr_n;
        end
    end

    // Purpose: qualify falling strobe edges and split command fields.
    always_comb begin
        wr_edge  = !cs_n && !wr_n && wr_n_q && rd_n;
        rd_edge  = !cs_n && !rd_n && rd_n_q && wr_n;
        cmd_wr   = wr_edge && (addr == CMD_ADDR);
        sel      = wdata[7:6];
        acc      = acc_e'(wdata[5:4]);
        is_multi = (sel == SEL_MULTI);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // Purpose: per-channel access and command request pulses.
        always_comb begin
            ch_we[i]    = wr_edge && (addr == ADDR_W'(i));
            ch_re[i]    = rd_edge && (addr == ADDR_W'(i));
            prog[i]     = cmd_wr && !is_multi && (sel == 2'(i)) && (acc != ACC_FREEZE);
            frz_cnt[i]  = cmd_wr && ((!is_multi && (sel == 2'(i)) && (acc == ACC_FREEZE))
                                  || (is_multi && !wdata[5] && wdata[1+i]));
            frz_stat[i] = cmd_wr && is_multi && !wdata[4] && wdata[1+i];
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
// One channel's registers: control bits, count register with write byte
// pointer, frozen count and status with read byte pointer.
// Assumes: request pulses are mutually exclusive within a cycle.
module tmr_chan_regs #(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic [5:0]        cw_bits,
    input  logic              frz_cnt,
    input  logic              frz_stat,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    input  logic              null_flag,
    output logic [DATA_W-1:0] rd_byte,
    output logic [CNT_W-1:0]  cr,
    output logic              cr_stb,
    output logic              cw_stb,
    output logic [5:0]        ctrl
);
    import tmr_pkg::*;

    localparam int HI_LSB = CNT_W - DATA_W;

    logic [5:0]        ctrl_q;
    logic [CNT_W-1:0]  cr_q, snap_q, src;
    logic [DATA_W-1:0] stat_q;
    logic              cnt_held, stat_held, rd_hi, wr_hi, cr_stb_q, cw_stb_q;
    logic              pick_hi, last_byte;
    acc_e              acc;

    // Purpose: choose the byte a read of this channel returns.
    always_comb begin
        acc       = acc_e'(ctrl_q[5:4]);
        src       = cnt_held ? snap_q : live_cnt;
        pick_hi   = (acc == ACC_HI) || ((acc == ACC_BOTH) && rd_hi);
        last_byte = (acc != ACC_BOTH) || rd_hi;
        rd_byte   = stat_held ? stat_q
                  : (pick_hi ? src[CNT_W-1:HI_LSB] : src[DATA_W-1:0]);
    end

    // Purpose: programming, count assembly, freezing and read pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= CTRL_RESET;
            cr_q      <= '0;
            snap_q    <= '0;
            stat_q    <= '0;
            cnt_held  <= 1'b0;
            stat_held <= 1'b0;
            rd_hi     <= 1'b0;
            wr_hi     <= 1'b0;
            cr_stb_q  <= 1'b0;
            cw_stb_q  <= 1'b0;
        end else begin
            cr_stb_q <= 1'b0;
            cw_stb_q <= 1'b0;
            if (prog) begin
                ctrl_q    <= cw_bits;
                cr_q      <= '0;
                rd_hi     <= 1'b0;
                wr_hi     <= 1'b0;
                cnt_held  <= 1'b0;
                stat_held <= 1'b0;
                cw_stb_q  <= 1'b1;
            end else begin
                if (frz_cnt && !cnt_held) begin
                    snap_q   <= live_cnt;
                    cnt_held <= 1'b1;
                end
                if (frz_stat && !stat_held) begin
                    stat_q    <= {out_lvl, null_flag, ctrl_q};
                    stat_held <= 1'b1;
                end
                if (we) begin
                    case (acc)
                        ACC_LO: begin
                            cr_q[DATA_W-1:0] <= wdata;
                            cr_stb_q         <= 1'b1;
                        end
                        ACC_HI: begin
                            cr_q[CNT_W-1:HI_LSB] <= wdata;
                            cr_stb_q             <= 1'b1;
                        end
                        ACC_BOTH: begin
                            if (wr_hi) begin
                                cr_q[CNT_W-1:HI_LSB] <= wdata;
                                cr_stb_q             <= 1'b1;
                            end else begin
                                cr_q[DATA_W-1:0] <= wdata;
                            end
                            wr_hi <= !wr_hi;
                        end
                        default: ;
                    endcase
                end
                if (re) begin
                    if (stat_held) begin
                        stat_held <= 1'b0;
                    end else begin
                        if (acc == ACC_BOTH) rd_hi <= !rd_hi;
                        if (last_byte) cnt_held <= 1'b0;
                    end
                end
            end
        end
    end

    assign cr     = cr_q;
    assign cr_stb = cr_stb_q;
    assign cw_stb = cw_stb_q;
    assign ctrl   = ctrl_q;

endmodule

// File: rtl/tmr_host_if.sv
// Top of the timer host interface: bus decode, one register set per channel
// and the registered read data path.
// Assumes: single clock domain; engine signals are synchronous to clk.
module tmr_host_if #(
    parameter int NCH    = 3,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic                 wr_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_oe,
    input  logic [NCH*CNT_W-1:0] live_cnt,
    input  logic [NCH-1:0]       out_lvl,
    input  logic [NCH-1:0]       null_flag,
    output logic [NCH*CNT_W-1:0] cr_val,
    output logic [NCH-1:0]       cr_stb,
    output logic [NCH-1:0]       cw_stb,
    output logic [NCH*6-1:0]     ctrl_word
);
    logic [NCH-1:0]    ch_we, ch_re, prog, frz_cnt, frz_stat;
    logic [DATA_W-1:0] ch_byte [NCH];
    logic [DATA_W-1:0] sel_byte;
    logic [DATA_W-1:0] rdata_q;

    tmr_bus_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .wdata    (wdata),
        .ch_we    (ch_we),
        .ch_re    (ch_re),
        .prog     (prog),
        .frz_cnt  (frz_cnt),
        .frz_stat (frz_stat)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tmr_chan_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .prog      (prog[i]),
            .cw_bits   (wdata[5:0]),
            .frz_cnt   (frz_cnt[i]),
            .frz_stat  (frz_stat[i]),
            .we        (ch_we[i]),
            .re        (ch_re[i]),
            .wdata     (wdata),
            .live_cnt  (live_cnt[i*CNT_W +: CNT_W]),
            .out_lvl   (out_lvl[i]),
            .null_flag (null_flag[i]),
            .rd_byte   (ch_byte[i]),
            .cr        (cr_val[i*CNT_W +: CNT_W]),
            .cr_stb    (cr_stb[i]),
            .cw_stb    (cw_stb[i]),
            .ctrl      (ctrl_word[i*6 +: 6])
        );
    end

    // Purpose: pick the addressed channel's byte.
    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(i)) sel_byte = ch_byte[i];
        end
    end

    // Purpose: capture read data on a qualified read edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (|ch_re) rdata_q <= sel_byte;
    end

    assign rdata    = rdata_q;
    assign rdata_oe = !cs_n && !rd_n && wr_n && (addr < ADDR_W'(NCH));

endmodule

// File: rtl/tmr_host_if_chk.sv
// Property checker for tmr_host_if, attached by bind below.
// Assumes: default parameters of the top (three 16-bit channels).
module tmr_host_if_chk #(
    parameter int NCH   = 3,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 wr_n,
    input logic [NCH*CNT_W-1:0] cr_val,
    input logic [NCH-1:0]       cr_stb,
    input logic [NCH-1:0]       cw_stb,
    input logic [NCH*6-1:0]     ctrl_word
);
    assert_stb_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_stb != '0) |-> $past(!cs_n && !wr_n));

    assert_one_cr_stb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cr_stb));

    assert_one_cw_stb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cw_stb));

    assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (cr_stb == '0 && cw_stb == '0));

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_stb == '0) |-> $stable(ctrl_word));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assert_prog_clears_cr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            cw_stb[i] |-> (cr_val[i*CNT_W +: CNT_W] == '0));
    end

endmodule

bind tmr_host_if tmr_host_if_chk u_chk (.*);

// File: tb/test_tmr_host_if.sv
module test_tmr_host_if;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic [47:0] live_cnt = '0;
    logic [2:0]  out_lvl = '0, null_flag = '0;
    logic [47:0] cr_val;
    logic [2:0]  cr_stb, cw_stb;
    logic [17:0] ctrl_word;

    int checks = 0, failures = 0;
    int rd_seen = 0, rd_done = 0;
    logic rd_prev = 1'b1;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    tmr_host_if i_tmr_host_if (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
        @(negedge clk); wr_n = 1; cs_n = 1;
    endtask

    // driver: push expected byte, then run the read strobe
    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
        @(negedge clk);
        check({tag, " R2 oe"}, rdata_oe, 1);
        rd_n = 1; cs_n = 1;
    endtask

    // monitor: count read edges as the bench sees them
    always @(posedge clk) begin
        if (!cs_n && !rd_n && wr_n && rd_prev && addr != 2'd3) rd_seen <= rd_seen + 1;
        rd_prev <= rd_n;
    end

    // monitor: pop and compare once the design has produced read data
    always @(negedge clk) begin
        if (rd_seen != rd_done) begin
            rd_done++;
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R6 unexpected read actual=%h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cr", cr_val, 0);
        check("R1 cr_stb", cr_stb, 0);
        check("R1 cw_stb", cw_stb, 0);
        check("R1 oe", rdata_oe, 0);
        check("R1 ctrl", ctrl_word, {3{6'h10}});

        // R6 default low-byte format reads live count
        live_cnt[15:0] = 16'h00A5;
        bus_rd(0, 8'hA5, "R6 lo only");
        bus_rd(0, 8'hA5, "R6 lo only again");

        // R3 control word and R4 two-byte assembly on channel 0
        bus_wr(3, 8'h34);
        check("R3 cw_stb", cw_stb, 3'b001);
        check("R3 ctrl0", ctrl_word[5:0], 6'h34);
        bus_wr(0, 8'hCD);
        check("R4 no stb after lo", cr_stb, 0);
        check("R4 cr0 lo", cr_val[15:0], 16'h00CD);
        bus_wr(0, 8'hAB);
        check("R4 stb after hi", cr_stb, 3'b001);
        check("R4 cr0 full", cr_val[15:0], 16'hABCD);

        // R4 one-byte formats, R3 clear on reprogram (channel 1)
        bus_wr(1, 8'h55);
        check("R4 lo stb", cr_stb, 3'b010);
        check("R4 cr1 lo", cr_val[31:16], 16'h0055);
        bus_wr(3, 8'h66);
        check("R3 cw_stb1", cw_stb, 3'b010);
        check("R3 cr1 cleared", cr_val[31:16], 16'h0000);
        bus_wr(1, 8'h12);
        check("R4 hi stb", cr_stb, 3'b010);
        check("R4 cr1 hi", cr_val[31:16], 16'h1200);

        // R2 deselected write, both strobes low, read at address 3
        @(negedge clk); cs_n = 1; wr_n = 0; addr = 1; wdata = 8'h99;
        @(negedge clk);
        check("R2 deselected stb", cr_stb, 0);
        wr_n = 1;
        @(negedge clk); cs_n = 0; wr_n = 0; rd_n = 0; wdata = 8'h77;
        @(negedge clk);
        check("R2 both low oe", rdata_oe, 0);
        check("R2 both low stb", cr_stb, 0);
        wr_n = 1; rd_n = 1; cs_n = 1;
        @(negedge clk); cs_n = 0; rd_n = 0; addr = 3;
        @(negedge clk);
        check("R2 addr3 oe", rdata_oe, 0);
        rd_n = 1; cs_n = 1;
        check("R2 cr1 kept", cr_val[31:16], 16'h1200);

        // R5 freeze, repeat ignored, R6 release then live
        live_cnt[15:0] = 16'h1234;
        bus_wr(3, 8'h00);
        check("R5 ctrl0 kept", ctrl_word[5:0], 6'h34);
        check("R5 no cw_stb", cw_stb, 0);
        live_cnt[15:0] = 16'h5678;
        bus_wr(3, 8'h00);
        bus_rd(0, 8'h34, "R5 frozen lo");
        bus_rd(0, 8'h12, "R5 frozen hi");
        bus_rd(0, 8'h78, "R6 live lo");
        bus_rd(0, 8'h56, "R6 live hi");

        // R7 multi-channel count+status, R8 status byte, R9 order
        out_lvl = 3'b100; null_flag = 3'b001;
        live_cnt[15:0] = 16'h2222; live_cnt[47:32] = 16'h0033;
        bus_wr(3, 8'hCA);
        out_lvl = 0; null_flag = 0;
        live_cnt[15:0] = 16'h9999; live_cnt[47:32] = 16'h0044;
        bus_wr(3, 8'hE2); // second status freeze on channel 0: ignored (R8)
        bus_rd(2, 8'h90, "R8 status ch2");
        bus_rd(2, 8'h33, "R9 count after status ch2");
        bus_rd(2, 8'h44, "R7 live after ch2");
        bus_rd(0, 8'h74, "R8 status ch0 first kept");
        bus_rd(0, 8'h22, "R9 count lo ch0");
        bus_rd(0, 8'h22, "R9 count hi ch0");
        bus_rd(0, 8'h99, "R7 live ch0");

        // R11 reprogram discards frozen count and status (channel 1)
        live_cnt[31:16] = 16'hBEEF;
        bus_wr(3, 8'h40);
        bus_wr(3, 8'hE4);
        live_cnt[31:16] = 16'hCAFE;
        bus_wr(3, 8'h66);
        bus_rd(1, 8'hCA, "R11 live after reprogram");

        // R10 interleaved pointers, foreign channel in between
        bus_wr(3, 8'h34);
        live_cnt[15:0] = 16'h4321;
        bus_rd(0, 8'h21, "R10 read lo");
        bus_wr(0, 8'h11);
        check("R10 no stb after lo", cr_stb, 0);
        bus_rd(0, 8'h43, "R10 read hi");
        bus_wr(2, 8'h5A);
        check("R10 foreign stb", cr_stb, 3'b100);
        bus_wr(0, 8'h22);
        check("R10 stb after hi", cr_stb, 3'b001);
        check("R10 cr0", cr_val[15:0], 16'h2211);

        // R3 reprogram resets write pointer
        bus_wr(0, 8'h77);
        bus_wr(3, 8'h34);
        bus_wr(0, 8'h88);
        check("R3 ptr reset no stb", cr_stb, 0);
        check("R3 ptr reset cr0", cr_val[15:0], 16'h0088);

        repeat (3) @(negedge clk);
        check("R6 all reads seen", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule